// File: doc/BRIEF.md
# Timer-Triggered Sample Sequencer FIFO Front End

This block is the digital side of a four-sequencer analog-to-digital front end. Each sequencer owns a 16-entry result FIFO, an enable bit, a 4-bit trigger-select field and an interrupt line. When the timer trigger input is high for a cycle, every enabled sequencer whose trigger select holds the timer code pushes one sample into its FIFO. Software drains results by reading a per-sequencer data register, and watches progress through a status word that packs both FIFO pointers and the empty and full flags.

Sample values come from the `conv_data_i` port when a converter is attached. With no converter, an internal linear congruential generator produces values in the range 0x200 to 0x207. Pushes raise raw interrupt bits, which are masked onto the `irq_o` outputs. Overflow and underflow events are latched in sticky registers that software clears by writing 1s.

Register map (byte offsets on an 8-bit bus address):
- Global registers: 0x00 enables; 0x04 raw interrupts (read only); 0x08 interrupt mask; 0x0C masked interrupts on read, clear by writing 1s; 0x10 overflow; 0x14 trigger selects; 0x18 underflow.
- Sequencer n has a window at 0x40 + 32·n containing: +0x0 input-mux word, +0x4 control word, +0x8 FIFO data (popped on read), +0xC FIFO status.

Top module: `adc_sfe_top`

## Requirements
- R1: After reset, every FIFO status word reads 0x00000100 (only the empty flag is set), and the enable, raw interrupt, overflow and underflow registers all read 0. `irq_o` is 0.
- R2: A cycle with `trig_i` high pushes into sequencer n only if enable bit n (register 0x00) is 1 and bits 4n+3:4n of register 0x14 equal 5. Any other code, or a cleared enable, leaves that FIFO unchanged.
- R3: The status word layout is: read pointer in bits 3:0, write pointer in bits 7:4, empty flag at bit 8, full flag at bit 12. An accepted push stores the sample, advances the write pointer modulo 16 and clears empty. Full is set when the write pointer then equals the read pointer. Full and empty are never both set.
- R4: A read of the data register of a non-empty FIFO returns the entry at the read pointer, zero-extended. The read pointer advances modulo 16 and full is cleared. Empty is set when the read pointer then equals the write pointer. Data comes out in push order.
- R5: A push into a full FIFO discards the sample, leaves the status word unchanged and sets bit n of the overflow register 0x10.
- R6: A data read from an empty FIFO returns 0, leaves the status word unchanged and sets bit n of the underflow register 0x18.
- R7: Writing 1s to register 0x10 or 0x18 clears the matching flags. Bits written as 0 are kept.
- R8: With `conv_attached_i` low, the generator state starts at 0 after reset. For each qualifying sequencer, taken in ascending index within a trigger, the state becomes state × 314159 + 1 (mod 2^32). That sequencer's sample is 0x200 plus bits 18:16 of the new state. The state advances even when the push is discarded.
- R9: With `conv_attached_i` high, every qualifying sequencer receives `conv_data_i` and the generator state holds.
- R10: Each accepted push into sequencer n sets raw bit n (register 0x04). `irq_o[n]` and bit n of a read of 0x0C equal raw bit n AND mask bit n (register 0x08).
- R11: Writing 1s to 0x0C clears the matching raw bits. A push in the same cycle sets its bit anyway.
- R12: When a push and a data read of the same FIFO fall in one cycle, both are judged on the flags from before that cycle. On an empty FIFO the read returns 0 and flags underflow, and the sample is kept. On a full FIFO the read returns the oldest entry and the sample is dropped with overflow. Otherwise both pointers advance and the flags hold.
- R13: A write to a sequencer's mux word stores the value ANDed with 0x33333333. The control word stores all 32 bits. Both read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| trig_i | input | 1 | Timer trigger, one trigger per high cycle |
| conv_attached_i | input | 1 | 1 = take samples from conv_data_i |
| conv_data_i | input | 10 | Converter sample |
| irq_o | output | 4 | Per-sequencer masked interrupts |

## Verification
The timer trigger and a software pop of the same FIFO can land in the same clock cycle. The bench drives `trig_i` and a data-register read together three times: on an empty FIFO, on a FIFO holding one entry, and on a full FIFO. It compares the returned data, the resulting status word and the overflow and underflow flags against a model that applies the pop and then the push using the pre-cycle occupancy. The same approach covers a raw-interrupt clear that coincides with a push, where the bench expects the new bit to survive.

// File: rtl/adc_sfe_pkg.sv
package adc_sfe_pkg;
  // global register byte offsets
  localparam int OFS_ENABLE = 'h00;
  localparam int OFS_RAW    = 'h04;
  localparam int OFS_MASK   = 'h08;
  localparam int OFS_MIS    = 'h0C;
  localparam int OFS_OVF    = 'h10;
  localparam int OFS_TSEL   = 'h14;
  localparam int OFS_UNF    = 'h18;
  // sequencer windows: 32 bytes each, first at 0x40 (window index 2)
  localparam int WIN_SHIFT  = 5;
  localparam int WIN_FIRST  = 2;
  localparam int SQ_MUX     = 'h0;
  localparam int SQ_CTL     = 'h4;
  localparam int SQ_DATA    = 'h8;
  localparam int SQ_STAT    = 'hC;
  // status word flag positions
  localparam int ST_EMPTY_BIT = 8;
  localparam int ST_FULL_BIT  = 12;
  localparam logic [3:0]  TSEL_TIMER = 4'd5;
  localparam logic [31:0] MUX_KEEP   = 32'h3333_3333;
  localparam logic [31:0] LCG_MUL    = 32'd314159;
  localparam int          SMPL_BASE  = 'h200;

  function automatic logic [31:0] lcg_next(input logic [31:0] s);
    return s * LCG_MUL + 32'd1;
  endfunction
endpackage

// File: rtl/adc_sfe_fifo.sv
module adc_sfe_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 10,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          pushed_o,
  output logic          dropped_o,
  output logic          starved_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic          empty_q, empty_d, full_q, full_d;
  logic          push_ok, pop_ok;

  // both decisions use the flags from before this cycle
  assign push_ok = push_i & ~full_q;
  assign pop_ok  = pop_i & ~empty_q;

  always_comb begin
    rd_d    = rd_q;
    wr_d    = wr_q;
    empty_d = empty_q;
    full_d  = full_q;
    if (push_ok) wr_d = wr_q + PW'(1);
    if (pop_ok)  rd_d = rd_q + PW'(1);
    if (push_ok && !pop_ok) begin
      empty_d = 1'b0;
      full_d  = (wr_d == rd_q);
    end else if (pop_ok && !push_ok) begin
      full_d  = 1'b0;
      empty_d = (rd_d == wr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= push_data_i;
  end

  assign pop_data_o = empty_q ? '0 : mem_q[rd_q];
  assign rd_ptr_o   = rd_q;
  assign wr_ptr_o   = wr_q;
  assign empty_o    = empty_q;
  assign full_o     = full_q;
  assign pushed_o   = push_ok;
  assign dropped_o  = push_i & full_q;
  assign starved_o  = pop_i & empty_q;
endmodule

// File: rtl/adc_sfe_lcg.sv
module adc_sfe_lcg
  import adc_sfe_pkg::*;
#(
  parameter int NSEQ = 4,
  parameter int DW   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSEQ-1:0]          adv_i,
  output logic [NSEQ-1:0][DW-1:0]  smpl_o
);
  logic [31:0]            state_q;
  logic [NSEQ:0][31:0]    chain;

  assign chain[0] = state_q;

  // one step per qualifying sequencer, ascending index
  for (genvar k = 0; k < NSEQ; k++) begin : g_step
    logic [31:0] stepped;
    assign stepped     = lcg_next(chain[k]);
    assign chain[k+1]  = adv_i[k] ? stepped : chain[k];
    assign smpl_o[k]   = DW'(SMPL_BASE) + DW'(stepped[18:16]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= '0;
    else if (|adv_i)  state_q <= chain[NSEQ];
  end
endmodule

// File: rtl/adc_sfe_top.sv
module adc_sfe_top
  import adc_sfe_pkg::*;
#(
  parameter int NSEQ  = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 10,
  parameter int AW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  input  logic            trig_i,
  input  logic            conv_attached_i,
  input  logic [DW-1:0]   conv_data_i,
  output logic [NSEQ-1:0] irq_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int TW = 4 * NSEQ;

  logic [NSEQ-1:0]         en_q, en_d, mask_q, mask_d, raw_q, raw_d;
  logic [NSEQ-1:0]         ovf_q, ovf_d, unf_q, unf_d;
  logic [TW-1:0]           tsel_q, tsel_d;
  logic [NSEQ-1:0][31:0]   smux_q, smux_d, sctl_q, sctl_d;

  logic                    wr_acc, rd_acc;
  logic [NSEQ-1:0]         win_hit, pop_req, qualify, pushed, dropped, starved;
  logic [NSEQ-1:0][DW-1:0] gen_smpl, pop_data;
  logic [NSEQ-1:0][31:0]   stat_w;

  assign wr_acc = bus_sel_i & bus_wr_i;
  assign rd_acc = bus_sel_i & ~bus_wr_i;

  adc_sfe_lcg #(.NSEQ(NSEQ), .DW(DW)) u_lcg (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (qualify & {NSEQ{~conv_attached_i}}),
    .smpl_o (gen_smpl)
  );

  for (genvar n = 0; n < NSEQ; n++) begin : g_seq
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          empty, full;
    logic [31:0]   word;

    assign win_hit[n] = bus_sel_i &&
                        (bus_addr_i[AW-1:WIN_SHIFT] == (AW-WIN_SHIFT)'(WIN_FIRST + n));
    assign pop_req[n] = win_hit[n] & ~bus_wr_i &
                        (bus_addr_i[WIN_SHIFT-1:0] == WIN_SHIFT'(SQ_DATA));
    assign qualify[n] = trig_i & en_q[n] & (tsel_q[4*n +: 4] == TSEL_TIMER);

    adc_sfe_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (qualify[n]),
      .push_data_i (conv_attached_i ? conv_data_i : gen_smpl[n]),
      .pop_i       (pop_req[n]),
      .pop_data_o  (pop_data[n]),
      .rd_ptr_o    (rd_ptr),
      .wr_ptr_o    (wr_ptr),
      .empty_o     (empty),
      .full_o      (full),
      .pushed_o    (pushed[n]),
      .dropped_o   (dropped[n]),
      .starved_o   (starved[n])
    );

    always_comb begin
      word                = '0;
      word[PW-1:0]        = rd_ptr;
      word[2*PW-1:PW]     = wr_ptr;
      word[ST_EMPTY_BIT]  = empty;
      word[ST_FULL_BIT]   = full;
    end
    assign stat_w[n] = word;
  end

  // next state of the register file
  always_comb begin
    logic [NSEQ-1:0] raw_clr, ovf_clr, unf_clr;
    raw_clr = '0;
    ovf_clr = '0;
    unf_clr = '0;
    en_d    = en_q;
    mask_d  = mask_q;
    tsel_d  = tsel_q;
    smux_d  = smux_q;
    sctl_d  = sctl_q;
    if (wr_acc) begin
      case (bus_addr_i)
        AW'(OFS_ENABLE): en_d    = bus_wdata_i[NSEQ-1:0];
        AW'(OFS_MASK):   mask_d  = bus_wdata_i[NSEQ-1:0];
        AW'(OFS_MIS):    raw_clr = bus_wdata_i[NSEQ-1:0];
        AW'(OFS_OVF):    ovf_clr = bus_wdata_i[NSEQ-1:0];
        AW'(OFS_TSEL):   tsel_d  = bus_wdata_i[TW-1:0];
        AW'(OFS_UNF):    unf_clr = bus_wdata_i[NSEQ-1:0];
        default: ;
      endcase
      for (int n = 0; n < NSEQ; n++) begin
        if (win_hit[n]) begin
          if (bus_addr_i[WIN_SHIFT-1:0] == WIN_SHIFT'(SQ_MUX))
            smux_d[n] = bus_wdata_i & MUX_KEEP;
          if (bus_addr_i[WIN_SHIFT-1:0] == WIN_SHIFT'(SQ_CTL))
            sctl_d[n] = bus_wdata_i;
        end
      end
    end
    // a new event wins over a clear in the same cycle
    raw_d = (raw_q & ~raw_clr) | pushed;
    ovf_d = (ovf_q & ~ovf_clr) | dropped;
    unf_d = (unf_q & ~unf_clr) | starved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      raw_q  <= '0;
      ovf_q  <= '0;
      unf_q  <= '0;
      tsel_q <= '0;
      smux_q <= '0;
      sctl_q <= '0;
    end else begin
      if (wr_acc) begin
        en_q   <= en_d;
        mask_q <= mask_d;
        tsel_q <= tsel_d;
        smux_q <= smux_d;
        sctl_q <= sctl_d;
      end
      raw_q <= raw_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // read data, valid during the access cycle
  always_comb begin
    bus_rdata_o = '0;
    if (rd_acc) begin
      case (bus_addr_i)
        AW'(OFS_ENABLE): bus_rdata_o = 32'(en_q);
        AW'(OFS_RAW):    bus_rdata_o = 32'(raw_q);
        AW'(OFS_MASK):   bus_rdata_o = 32'(mask_q);
        AW'(OFS_MIS):    bus_rdata_o = 32'(raw_q & mask_q);
        AW'(OFS_OVF):    bus_rdata_o = 32'(ovf_q);
        AW'(OFS_TSEL):   bus_rdata_o = 32'(tsel_q);
        AW'(OFS_UNF):    bus_rdata_o = 32'(unf_q);
        default: ;
      endcase
      for (int n = 0; n < NSEQ; n++) begin
        if (win_hit[n]) begin
          case (bus_addr_i[WIN_SHIFT-1:0])
            WIN_SHIFT'(SQ_MUX):  bus_rdata_o = smux_q[n];
            WIN_SHIFT'(SQ_CTL):  bus_rdata_o = sctl_q[n];
            WIN_SHIFT'(SQ_DATA): bus_rdata_o = 32'(pop_data[n]);
            WIN_SHIFT'(SQ_STAT): bus_rdata_o = stat_w[n];
            default: ;
          endcase
        end
      end
    end
  end

  assign irq_o = raw_q & mask_q;
endmodule

// File: rtl/adc_sfe_chk.sv
module adc_sfe_chk #(
  parameter int NSEQ = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   trig_i,
  input logic [NSEQ-1:0]        en,
  input logic [4*NSEQ-1:0]      tsel,
  input logic [NSEQ-1:0][31:0]  stat,
  input logic [NSEQ-1:0]        raw,
  input logic [NSEQ-1:0]        mask,
  input logic [NSEQ-1:0]        irq,
  input logic [NSEQ-1:0]        pop,
  input logic [31:0]            rdata
);
  for (genvar n = 0; n < NSEQ; n++) begin : g_chk
    AST_NO_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat[n][12] && stat[n][8])); // R3

    AST_UNSELECTED_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_i && en[n] && tsel[4*n +: 4] == 4'd5) |=> $stable(stat[n][7:4])); // R2

    AST_PUSH_RAISES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[n][7:4] != $past(stat[n][7:4])) |-> raw[n]); // R10

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      irq[n] |-> (mask[n] && raw[n])); // R10

    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pop[n] && stat[n][8]) |-> (rdata == 32'd0)); // R6

    AST_EMPTY_POP_KEEPS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop[n] && stat[n][8] && !trig_i) |=> $stable(stat[n])); // R6
  end
endmodule

bind adc_sfe_top adc_sfe_chk #(.NSEQ(NSEQ)) u_adc_sfe_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .trig_i (trig_i),
  .en     (en_q),
  .tsel   (tsel_q),
  .stat   (stat_w),
  .raw    (raw_q),
  .mask   (mask_q),
  .irq    (irq_o),
  .pop    (pop_req),
  .rdata  (bus_rdata_o)
);

// File: tb/test_adc_sfe_top.sv
module test_adc_sfe_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, trig, conv_att;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [9:0]  conv_data;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_lcg;
  logic [9:0]  m_mem [4][16];
  int          m_rd [4], m_wr [4], m_cnt [4];
  logic [3:0]  m_en, m_raw, m_ovf, m_unf;
  logic [15:0] m_tsel;

  always #5 clk = ~clk;

  adc_sfe_top i_adc_sfe_top (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .trig_i(trig), .conv_attached_i(conv_att), .conv_data_i(conv_data), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_stat(input int n);
    return {19'd0, (m_cnt[n] == 16), 3'd0, (m_cnt[n] == 0), m_wr[n][3:0], m_rd[n][3:0]};
  endfunction

  // blk0: sequencer 0 counts as full for this trigger (pre-cycle view)
  task automatic m_push_all(input bit blk0);
    for (int n = 0; n < 4; n++) begin
      if (m_en[n] && m_tsel[4*n +: 4] == 4'd5) begin
        logic [9:0] s;
        bit full;
        if (!conv_att) begin
          m_lcg = m_lcg * 32'd314159 + 32'd1;
          s = 10'h200 + {7'd0, m_lcg[18:16]};
        end else s = conv_data;
        full = (m_cnt[n] == 16) || (n == 0 && blk0);
        if (!full) begin
          m_mem[n][m_wr[n]] = s;
          m_wr[n] = (m_wr[n] + 1) % 16;
          m_cnt[n]++;
          m_raw[n] = 1'b1;
        end else m_ovf[n] = 1'b1;
      end
    end
  endtask

  task automatic m_pop(input int n, output logic [31:0] exp);
    if (m_cnt[n] == 0) begin
      exp = 0;
      m_unf[n] = 1'b1;
    end else begin
      exp = {22'd0, m_mem[n][m_rd[n]]};
      m_rd[n] = (m_rd[n] + 1) % 16;
      m_cnt[n]--;
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_chk(input string req, input string what, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic fire();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    m_push_all(0);
  endtask

  task automatic pop_chk(input string req, input int n);
    logic [31:0] e;
    m_pop(n, e);
    rd_chk(req, "fifo data", 8'h48 + 8'(32 * n), e);
  endtask

  task automatic t_reset();
    for (int n = 0; n < 4; n++) rd_chk("R1", "status after reset", 8'h4C + 8'(32 * n), 32'h100);
    rd_chk("R1", "enable", 8'h00, 0);
    rd_chk("R1", "raw", 8'h04, 0);
    rd_chk("R1", "overflow", 8'h10, 0);
    rd_chk("R1", "underflow", 8'h18, 0);
    chk("R1", "irq", {28'd0, irq}, 0);
  endtask

  task automatic t_gating();
    m_en = 4'b0111; m_tsel = 16'h5455;
    bus_write(8'h00, 32'h7);
    bus_write(8'h14, 32'h5455);
    fire();
    for (int n = 0; n < 4; n++) rd_chk("R2", "status after trigger", 8'h4C + 8'(32 * n), m_stat(n));
    pop_chk("R8", 0);
    pop_chk("R8", 1);
    bus_write(8'h80, 32'hFFFF_FFFF);
    rd_chk("R13", "mux masked", 8'h80, 32'h3333_3333);
    bus_write(8'h84, 32'hABCD_1234);
    rd_chk("R13", "control word", 8'h84, 32'hABCD_1234);
  endtask

  task automatic t_fill_drain();
    m_en = 4'b0001;
    bus_write(8'h00, 32'h1);
    for (int i = 0; i < 16; i++) fire();
    rd_chk("R3", "status full", 8'h4C, m_stat(0));
    chk("R3", "model full word", m_stat(0), 32'h1011);
    fire();
    rd_chk("R5", "status unchanged on overflow", 8'h4C, 32'h1011);
    rd_chk("R5", "overflow flag", 8'h10, 32'h1);
    bus_write(8'h10, 32'h0);
    rd_chk("R7", "zero write keeps overflow", 8'h10, 32'h1);
    bus_write(8'h10, 32'h1);
    rd_chk("R7", "overflow cleared", 8'h10, 0);
    m_ovf = 0;
    for (int i = 0; i < 16; i++) pop_chk("R4", 0);
    rd_chk("R4", "status empty after drain", 8'h4C, 32'h111);
    pop_chk("R6", 0);
    rd_chk("R6", "status unchanged on underflow", 8'h4C, 32'h111);
    rd_chk("R6", "underflow flag", 8'h18, 32'h1);
    bus_write(8'h18, 32'h1);
    rd_chk("R7", "underflow cleared", 8'h18, 0);
    m_unf = 0;
  endtask

  task automatic t_irq();
    bus_write(8'h08, 32'h1);
    @(negedge clk); #1;
    chk("R10", "irq masked", {28'd0, irq}, {28'd0, m_raw & 4'h1});
    rd_chk("R10", "raw", 8'h04, {28'd0, m_raw});
    rd_chk("R10", "masked read", 8'h0C, {28'd0, m_raw & 4'h1});
    bus_write(8'h0C, 32'hF);
    m_raw = 0;
    rd_chk("R11", "raw cleared", 8'h04, 0);
    chk("R11", "irq after clear", {28'd0, irq}, 0);
    // clear and push in the same cycle
    @(negedge clk);
    trig = 1; bus_sel = 1; bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'hF;
    @(negedge clk);
    trig = 0; bus_sel = 0; bus_wr = 0;
    m_push_all(0);
    rd_chk("R11", "push wins over clear", 8'h04, 32'h1);
    #1 chk("R10", "irq raised by push", {28'd0, irq}, 32'h1);
  endtask

  task automatic t_external();
    conv_att = 1; conv_data = 10'h155;
    fire();
    conv_att = 0;
    pop_chk("R9", 0);
    pop_chk("R9", 0);
    fire();
    pop_chk("R8", 0);
    rd_chk("R8", "status", 8'h4C, m_stat(0));
  endtask

  task automatic trig_pop(input string req);
    logic [31:0] d, e;
    int pre;
    pre = m_cnt[0];
    @(negedge clk);
    trig = 1; bus_sel = 1; bus_wr = 0; bus_addr = 8'h48;
    #1 d = bus_rdata;
    @(negedge clk);
    trig = 0; bus_sel = 0;
    m_pop(0, e);
    m_push_all(pre == 16);
    chk(req, "same-cycle pop data", d, e);
    rd_chk(req, "same-cycle status", 8'h4C, m_stat(0));
  endtask

  task automatic t_same_cycle();
    rd_chk("R12", "starting empty", 8'h4C, m_stat(0));
    trig_pop("R12");
    rd_chk("R12", "underflow from empty", 8'h18, 32'h1);
    bus_write(8'h18, 32'h1); m_unf = 0;
    trig_pop("R12");
    for (int i = 0; i < 15; i++) fire();
    chk("R12", "model full before", m_stat(0) >> 12, 1);
    trig_pop("R12");
    rd_chk("R12", "overflow from full", 8'h10, 32'h1);
    for (int i = 0; i < 15; i++) pop_chk("R4", 0);
    rd_chk("R12", "drained", 8'h4C, m_stat(0));
  endtask

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    trig = 0; conv_att = 0; conv_data = 0;
    m_lcg = 0; m_en = 0; m_raw = 0; m_ovf = 0; m_unf = 0; m_tsel = 0;
    for (int n = 0; n < 4; n++) begin m_rd[n] = 0; m_wr[n] = 0; m_cnt[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gating();
    t_fill_drain();
    t_irq();
    t_external();
    t_same_cycle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule